// File: doc/BRIEF.md
# MSI capability register file

This block holds the configuration-space registers of a message-signalled-interrupt capability. Software reaches them through a simple dword-wide register port with byte enables. The port address is a byte offset from the capability base, and its two low bits are ignored. The stored registers are a control word, the message address (low word, plus a high word when 64-bit addressing is built in), the 16-bit message data and, when per-vector masking is built in, a mask word and a pending word. Parameters fix the capable vector count and the two build options, and the window length and register offsets follow from them.

Writes go through per-bit write masks. A control write that enables the capability and asks for more vectors than the block can handle is pulled back to the capable count. An asynchronous reset clears all software state, while the read-only capability flags keep their values. The decoded enable, vector count, address, data and mask go straight to the interrupt dispatcher. The dispatcher sets and clears the pending bits through its own strobes. While the capability is enabled, a dedicated output tells the legacy INTx logic to hold its request inactive.

Top module: `msi_cap_regs`

## Requirements
- R1: The window is 10, 14, 20 or 24 bytes long. The length is 10 with 32-bit addressing and no masking, 14 with 64-bit addressing and no masking, 20 with 32-bit addressing and masking, and 24 with both options. Any byte at an offset at or beyond the length reads as zero, and a write to it changes nothing.
- R2: The control word sits at byte offset 2, which is bits 31:16 of dword 0, and bytes 0 and 1 read as zero. Its fields are: bit 0 enable (RW), bits 3:1 capable count log2(NUM_VEC) (RO), bits 6:4 requested count (RW), bit 7 the 64-bit flag (RO), bit 8 the mask-capable flag (RO). Bits 15:9 read as zero, and writes to byte 3 have no effect.
- R3: If a control write sets the enable bit together with a requested count above the capable count, the requested count is stored as the capable count. With the enable bit clear, any requested value 0..7 is stored as written.
- R4: The low address is at offset 4. Its bits 31:2 are writable and its bits 1:0 always read as zero.
- R5: With 64-bit addressing, the high address is at offset 8 and all 32 bits are writable. msg_addr_o is {high, low}.
- R6: The 16-bit data register is at offset 12 with 64-bit addressing, or 8 without it, in bits 15:0. Bits 31:16 of that dword read as zero.
- R7: With masking, the mask word is at offset 16 with 64-bit addressing, or 12 without it. Only bits 0..NUM_VEC-1 are writable, and the higher bits read as zero.
- R8: With masking, the pending word is at offset 20 with 64-bit addressing, or 16 without it. The register port cannot write it. pend_set_i sets bits and pend_clr_i clears them, one cycle after the strobe. When both strobes hit the same bit, the set wins.
- R9: Reset clears the enable bit, the requested count, both address words, the data, the mask and the pending word. The read-only control bits keep their values.
- R10: intx_off_o is high exactly while the enable bit is set.
- R11: Only bytes whose be_i bit is set are written. With wr_i low, no register changes.
- R12: nvec_o equals 2 to the power of the stored requested count, and en_o shows the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | AW | Byte offset from capability base, dword aligned |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pend_set_i | input | NUM_VEC | Pending set strobes from dispatcher |
| pend_clr_i | input | NUM_VEC | Pending clear strobes from dispatcher |
| en_o | output | 1 | Capability enabled |
| intx_off_o | output | 1 | Force legacy INTx request inactive |
| nvec_o | output | 8 | Enabled vector count |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 16 | Message data |
| mask_o | output | NUM_VEC | Per-vector mask |
| pend_o | output | NUM_VEC | Per-vector pending bits |

## Verification
Each register write is read back at the same offset. All-ones data shows the effect of the per-bit write masks: the hardwired address bits, the upper half of the data dword, the mask bits above the vector count and the read-only pending word. Single-byte writes show that byte enables keep the other lanes intact. Control writes with the requested count above the capable count are made once with enable set and once with it clear, which separates clamping from plain storage. A write past the window end and simultaneous set and clear strobes on the pending word show the out-of-window rule and the set-over-clear priority. A mid-run reset shows which control bits survive.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  // control word bit positions, decoded by software
  localparam int unsigned CW_EN  = 0;
  localparam int unsigned CW_MMC = 1;
  localparam int unsigned CW_MME = 4;
  localparam int unsigned CW_A64 = 7;
  localparam int unsigned CW_PVM = 8;

  function automatic int unsigned cap_len(input bit a64, input bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  // dword indices that move with the 64-bit option
  function automatic int unsigned data_dw(input bit a64);
    return a64 ? 3 : 2;
  endfunction

  function automatic int unsigned mask_dw(input bit a64);
    return a64 ? 4 : 3;
  endfunction

  function automatic int unsigned pend_dw(input bit a64);
    return a64 ? 5 : 4;
  endfunction
endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit PVM    = 1'b1,
  parameter int AW     = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    be_i,
  input  logic          wr_i,
  output logic [3:0]    lane_ok_o,
  output logic [3:0]    wbe_o,
  output logic          sel_ctrl_o,
  output logic          sel_alo_o,
  output logic          sel_ahi_o,
  output logic          sel_data_o,
  output logic          sel_mask_o,
  output logic          sel_pend_o
);
  localparam int DW = AW - 2;
  localparam logic [AW-1:0] LEN = AW'(cap_len(ADDR64, PVM));

  logic [DW-1:0] dw;
  logic          unused_lsb;

  assign dw         = addr_i[AW-1:2];
  assign unused_lsb = ^addr_i[1:0];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_ok_o[l] = ({dw, 2'(l)} < LEN);
    assign wbe_o[l]     = wr_i & be_i[l] & lane_ok_o[l];
  end

  assign sel_ctrl_o = (dw == DW'(0));
  assign sel_alo_o  = (dw == DW'(1));
  assign sel_ahi_o  = ADDR64 && (dw == DW'(2));
  assign sel_data_o = (dw == DW'(data_dw(ADDR64)));
  assign sel_mask_o = PVM && (dw == DW'(mask_dw(ADDR64)));
  assign sel_pend_o = PVM && (dw == DW'(pend_dw(ADDR64)));
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int LOG_NV = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  output logic       en_o,
  output logic [2:0] mme_o
);
  logic [2:0] nx_mme;
  logic       unused_bits;

  assign unused_bits = ^{wbyte_i[7], wbyte_i[3:1]};

  // requested count above the capable count is pulled back when enabling
  always_comb begin
    nx_mme = wbyte_i[6:4];
    if (wbyte_i[0] && (nx_mme > 3'(LOG_NV))) nx_mme = 3'(LOG_NV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      mme_o <= '0;
    end else if (wr_i) begin
      en_o  <= wbyte_i[0];
      mme_o <= nx_mme;
    end
  end
endmodule

// File: rtl/msi_cap_vec.sv
module msi_cap_vec #(
  parameter int NV = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    mask_we_i,
  input  logic [31:0]   wdata_i,
  input  logic [NV-1:0] pend_set_i,
  input  logic [NV-1:0] pend_clr_i,
  output logic [NV-1:0] mask_o,
  output logic [NV-1:0] pend_o
);
  logic unused_in;

  assign unused_in = ^{mask_we_i, wdata_i};

  for (genvar b = 0; b < NV; b++) begin : g_bit
    logic m_q, p_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) m_q <= 1'b0;
      else if (mask_we_i[b/8]) m_q <= wdata_i[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else if (pend_set_i[b]) p_q <= 1'b1;
      else if (pend_clr_i[b]) p_q <= 1'b0;
    end

    assign mask_o[b] = m_q;
    assign pend_o[b] = p_q;
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter bit ADDR64  = 1'b1,
  parameter bit PVM     = 1'b1,
  parameter int AW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  output logic               en_o,
  output logic               intx_off_o,
  output logic [7:0]         nvec_o,
  output logic [63:0]        msg_addr_o,
  output logic [15:0]        msg_data_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] pend_o
);
  localparam int LOG_NV = $clog2(NUM_VEC);

  logic [3:0]  lane_ok, wbe;
  logic        sel_ctrl, sel_alo, sel_ahi, sel_data, sel_mask, sel_pend;
  logic        en_q;
  logic [2:0]  mme_q;
  logic [15:0] ctrl_word;
  logic [31:2] alo_q;
  logic [31:0] ahi_q;
  logic [15:0] data_q;
  logic [31:0] raw, lane_mask;

  msi_cap_decode #(.ADDR64(ADDR64), .PVM(PVM), .AW(AW)) u_dec (
    .addr_i     (addr_i),
    .be_i       (be_i),
    .wr_i       (wr_i),
    .lane_ok_o  (lane_ok),
    .wbe_o      (wbe),
    .sel_ctrl_o (sel_ctrl),
    .sel_alo_o  (sel_alo),
    .sel_ahi_o  (sel_ahi),
    .sel_data_o (sel_data),
    .sel_mask_o (sel_mask),
    .sel_pend_o (sel_pend)
  );

  msi_cap_ctrl #(.LOG_NV(LOG_NV)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_ctrl & wbe[2]),
    .wbyte_i (wdata_i[23:16]),
    .en_o    (en_q),
    .mme_o   (mme_q)
  );

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[CW_EN]             = en_q;
    ctrl_word[CW_MMC +: 3]       = 3'(LOG_NV);
    ctrl_word[CW_MME +: 3]       = mme_q;
    ctrl_word[CW_A64]            = ADDR64;
    ctrl_word[CW_PVM]            = PVM;
  end

  // low address, bits 1:0 hardwired to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alo_q <= '0;
    end else if (sel_alo) begin
      if (wbe[0]) alo_q[7:2]   <= wdata_i[7:2];
      if (wbe[1]) alo_q[15:8]  <= wdata_i[15:8];
      if (wbe[2]) alo_q[23:16] <= wdata_i[23:16];
      if (wbe[3]) alo_q[31:24] <= wdata_i[31:24];
    end
  end

  if (ADDR64) begin : g_ahi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ahi_q <= '0;
      end else if (sel_ahi) begin
        for (int l = 0; l < 4; l++) if (wbe[l]) ahi_q[8*l +: 8] <= wdata_i[8*l +: 8];
      end
    end
  end else begin : g_no_ahi
    assign ahi_q = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (sel_data) begin
      if (wbe[0]) data_q[7:0]  <= wdata_i[7:0];
      if (wbe[1]) data_q[15:8] <= wdata_i[15:8];
    end
  end

  if (PVM) begin : g_vec
    msi_cap_vec #(.NV(NUM_VEC)) u_vec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mask_we_i  (wbe & {4{sel_mask}}),
      .wdata_i    (wdata_i),
      .pend_set_i (pend_set_i),
      .pend_clr_i (pend_clr_i),
      .mask_o     (mask_o),
      .pend_o     (pend_o)
    );
  end else begin : g_no_vec
    logic unused_pend;
    assign unused_pend = ^{pend_set_i, pend_clr_i};
    assign mask_o = '0;
    assign pend_o = '0;
  end

  // read path: select dword, then blank bytes beyond the window
  always_comb begin
    raw = '0;
    if (sel_ctrl)      raw = {ctrl_word, 16'h0000};
    else if (sel_alo)  raw = {alo_q, 2'b00};
    else if (sel_ahi)  raw = ahi_q;
    else if (sel_data) raw = {16'h0000, data_q};
    else if (sel_mask) raw = 32'(mask_o);
    else if (sel_pend) raw = 32'(pend_o);
  end

  for (genvar l = 0; l < 4; l++) begin : g_rmask
    assign lane_mask[8*l +: 8] = {8{lane_ok[l]}};
  end

  assign rdata_o    = raw & lane_mask;
  assign en_o       = en_q;
  assign intx_off_o = en_q;
  assign nvec_o     = 8'd1 << mme_q;
  assign msg_addr_o = {ahi_q, alo_q, 2'b00};
  assign msg_data_o = data_q;
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int NUM_VEC = 8,
  parameter int AW      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [AW-1:0]      addr_i,
  input logic               be2_i,
  input logic               wbit_en_i,
  input logic [NUM_VEC-1:0] pend_set_i,
  input logic               en_o,
  input logic               intx_off_o,
  input logic [7:0]         nvec_o,
  input logic [63:0]        msg_addr_o,
  input logic [15:0]        msg_data_o,
  input logic [NUM_VEC-1:0] mask_o,
  input logic [NUM_VEC-1:0] pend_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[AW-1:2] == '0 && be2_i) |=> (en_o == $past(wbit_en_i)));

  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (nvec_o <= 8'(NUM_VEC)));

  p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_set_i) |=> ((pend_o & $past(pend_set_i)) == $past(pend_set_i)));

  p_intx_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intx_off_o) |-> $past(wr_i));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(msg_addr_o) && $stable(msg_data_o) && $stable(mask_o) && $stable(en_o)));
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.NUM_VEC(NUM_VEC), .AW(AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .be2_i      (be_i[2]),
  .wbit_en_i  (wdata_i[16]),
  .pend_set_i (pend_set_i),
  .en_o       (en_o),
  .intx_off_o (intx_off_o),
  .nvec_o     (nvec_o),
  .msg_addr_o (msg_addr_o),
  .msg_data_o (msg_data_o),
  .mask_o     (mask_o),
  .pend_o     (pend_o)
);

// File: tb/msi_cap_regs_tb_top.sv
module msi_cap_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int NT = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NV-1:0] pend_set_i = '0;
  logic [NV-1:0] pend_clr_i = '0;
  logic          en_o, intx_off_o;
  logic [7:0]    nvec_o;
  logic [63:0]   msg_addr_o;
  logic [15:0]   msg_data_o;
  logic [NV-1:0] mask_o, pend_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  msi_cap_regs #(.NUM_VEC(NV), .ADDR64(1'b1), .PVM(1'b1), .AW(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_set_i(pend_set_i),
    .pend_clr_i(pend_clr_i), .en_o(en_o), .intx_off_o(intx_off_o),
    .nvec_o(nvec_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .mask_o(mask_o), .pend_o(pend_o)
  );

  // write then read back at the same offset
  localparam logic [7:0]  T_ADDR [NT] = '{8'd4, 8'd8, 8'd12, 8'd16, 8'd16, 8'd4,
                                          8'd0, 8'd0, 8'd0, 8'd20, 8'd24, 8'd0};
  localparam logic [3:0]  T_BE   [NT] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'h1, 4'h2,
                                          4'hF, 4'h4, 4'h4, 4'hF, 4'hF, 4'h4};
  localparam logic [31:0] T_WD   [NT] = '{32'hDEADBEEF, 32'h12345678, 32'hFFFFA5A5,
                                          32'hFFFFFFFF, 32'h0000005A, 32'h00003300,
                                          32'hFFFFFFFF, 32'h00000000, 32'h00700000,
                                          32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00210000};
  localparam logic [31:0] T_EXP  [NT] = '{32'hDEADBEEC,  // R4
                                          32'h12345678,  // R5
                                          32'h0000A5A5,  // R6
                                          32'h000000FF,  // R7
                                          32'h0000005A,  // R7
                                          32'hDEAD33EC,  // R11
                                          32'h01B70000,  // R3 enable with count 7
                                          32'h01860000,  // R2
                                          32'h01F60000,  // R3 no clamp while disabled
                                          32'h00000000,  // R8 read-only
                                          32'h00000000,  // R1 past window
                                          32'h01A70000}; // R2
  localparam int          T_REQ  [NT] = '{4, 5, 6, 7, 7, 11, 3, 2, 3, 8, 1, 2};

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; be_i = be; wdata_i = wd;
    @(negedge clk_i);
    wr_i = 1'b0; be_i = '0; wdata_i = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    #(3*CLK_PERIOD);
    @(negedge clk_i);
    // R9 reset state
    do_read(8'd0, rd); chk(9, 64'(rd), 64'h01860000, "ctrl after reset");
    chk(9, msg_addr_o, 64'h0, "addr after reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NT; i++) begin
      do_write(T_ADDR[i], T_BE[i], T_WD[i]);
      do_read(T_ADDR[i], rd);
      chk(T_REQ[i], 64'(rd), 64'(T_EXP[i]), $sformatf("vector %0d readback", i));
    end

    // R12 R10 decoded outputs after enable with count 2
    chk(12, 64'(nvec_o), 64'd4, "nvec_o");
    chk(12, 64'(en_o), 64'd1, "en_o");
    chk(10, 64'(intx_off_o), 64'd1, "intx_off_o");
    chk(5, msg_addr_o, 64'h12345678_DEAD33EC, "msg_addr_o");
    chk(6, 64'(msg_data_o), 64'hA5A5, "msg_data_o");
    chk(7, 64'(mask_o), 64'h5A, "mask_o");
    do_read(8'd0, rd); chk(1, 64'(rd[15:0]), 64'h0, "header bytes zero");

    // R8 pending set and clear, set wins
    @(negedge clk_i); pend_set_i = 8'h81;
    @(negedge clk_i); pend_set_i = '0;
    do_read(8'd20, rd); chk(8, 64'(rd), 64'h81, "pending after set");
    pend_set_i = 8'h02; pend_clr_i = 8'h82;
    @(negedge clk_i); pend_set_i = '0; pend_clr_i = '0;
    do_read(8'd20, rd); chk(8, 64'(rd), 64'h03, "pending set over clear");

    // R10 disable drops the INTx override
    do_write(8'd0, 4'h4, 32'h0);
    chk(10, 64'(intx_off_o), 64'd0, "intx_off_o after disable");

    // R9 mid-run reset
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    do_read(8'd0, rd);  chk(9, 64'(rd), 64'h01860000, "ctrl after reset");
    do_read(8'd4, rd);  chk(9, 64'(rd), 64'h0, "addr lo after reset");
    do_read(8'd8, rd);  chk(9, 64'(rd), 64'h0, "addr hi after reset");
    do_read(8'd12, rd); chk(9, 64'(rd), 64'h0, "data after reset");
    do_read(8'd16, rd); chk(9, 64'(rd), 64'h0, "mask after reset");
    do_read(8'd20, rd); chk(9, 64'(rd), 64'h0, "pending after reset");
    chk(9, 64'(en_o), 64'd0, "en_o after reset");
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule